// File: doc/BRIEF.md
# DC-Only Inverse Transform Adder

This block reconstructs a pixel block whose residual has a single non-zero coefficient, the DC term. When the DC value is loaded, the block turns it into one signed offset. The offset comes from two rounded multiply-and-shift stages, and each of the four block shapes has its own constants. The offset is held in a register. Every predicted row presented afterwards gets that offset added to each 8-bit pixel, and each sum is clamped to 0..255.

A block shape is chosen with a 2-bit selector when the DC value is loaded. Rows arrive one per cycle with a valid strobe and leave one cycle later, also with a valid strobe. A row carries eight pixel lanes. Lane k sits in bits [8k+7:8k], and lane 0 is the leftmost pixel. For shapes four pixels wide only lanes 0..3 carry data. The caller decides how many rows make up a block. Parsing coefficients and addressing the frame buffer are done elsewhere.

Top module: `dc_recon_adder`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is 0 and out_pix is all zeros until the first row is accepted.
- R2: Shape code 0 (8 wide, 8 tall) gives offset e = (3*a + 16) >>> 5, where a = (3*dc + 1) >>> 1.
- R3: Shape code 1 (8 wide, 4 tall) gives offset e = (17*a + 64) >>> 7, where a = (3*dc + 1) >>> 1.
- R4: Shape code 2 (4 wide, 8 tall) gives offset e = (12*a + 64) >>> 7, where a = (17*dc + 4) >>> 3.
- R5: Shape code 3 (4 wide, 4 tall) gives offset e = (17*a + 64) >>> 7, where a = (17*dc + 4) >>> 3.
- R6: Every right shift is arithmetic, so a negative biased value rounds toward minus infinity. For example, dc = -11 with code 0 gives offset -1, and dc = -8 with code 3 gives offset -2.
- R7: Each output lane equals the zero-extended input pixel plus the offset, saturated to 0..255. When the offset is at least 255, every active lane reads 255.
- R8: A row presented with row_valid in cycle t appears on out_pix with out_valid high in cycle t+1. out_valid is high only in those cycles, so back-to-back rows stream at one per cycle.
- R9: The offset is captured on a cycle with dc_load high and is held until the next load. A row presented in the same cycle as a load uses the offset that was held before that load.
- R10: For shape codes 2 and 3, output lanes 4..7 are zero whatever the input lanes 4..7 carry.
- R11: In a cycle with no accepted row, out_pix keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dc_load | input | 1 | Capture dc_val and blk_size and compute a new offset |
| dc_val | input | 16 | Signed DC coefficient |
| blk_size | input | 2 | Shape code: 0 = 8x8, 1 = 8 wide by 4 tall, 2 = 4 wide by 8 tall, 3 = 4x4 |
| row_valid | input | 1 | row_pix holds a predicted row |
| row_pix | input | 64 | Eight 8-bit predicted pixels, lane 0 in the low byte |
| out_valid | output | 1 | out_pix holds a reconstructed row |
| out_pix | output | 64 | Eight 8-bit reconstructed pixels, lane 0 in the low byte |

## Verification
The bench applies negative DC values whose biased products are not multiples of the shift divisor. A design that truncated toward zero, or used a logical shift, would give offsets one step too high or wildly wrong. It drives the extreme DC values against pixels of 0 and 255. A design that wrapped instead of clamping, or that sign-extended the pixel, would produce garbage near the rails. It also loads a new DC value in the same cycle as a row. A design that forwarded the new offset would alter that row. Finally, it fills the unused upper lanes of narrow shapes with non-zero data, and a design without the lane mask would leak those lanes to the output.

// File: rtl/dcadd_pkg.sv
package dcadd_pkg;

    typedef enum logic [1:0] {
        SHP_8X8 = 2'd0,
        SHP_8W4 = 2'd1,
        SHP_4W8 = 2'd2,
        SHP_4X4 = 2'd3
    } shape_e;

endpackage

// File: rtl/dcadd_scale.sv
module dcadd_scale
    import dcadd_pkg::*;
#(
    parameter int DC_W  = 16,
    parameter int ACC_W = 24
) (
    input  logic signed [DC_W-1:0]  dc,
    input  shape_e                  shape,
    output logic signed [ACC_W-1:0] ofs
);
    localparam logic signed [ACC_W-1:0] K1  = ACC_W'(1);
    localparam logic signed [ACC_W-1:0] K3  = ACC_W'(3);
    localparam logic signed [ACC_W-1:0] K4  = ACC_W'(4);
    localparam logic signed [ACC_W-1:0] K12 = ACC_W'(12);
    localparam logic signed [ACC_W-1:0] K16 = ACC_W'(16);
    localparam logic signed [ACC_W-1:0] K17 = ACC_W'(17);
    localparam logic signed [ACC_W-1:0] K64 = ACC_W'(64);

    logic signed [ACC_W-1:0] ext;
    logic signed [ACC_W-1:0] stage1;

    assign ext = {{(ACC_W-DC_W){dc[DC_W-1]}}, dc};

    // Stage one depends on block width, stage two on the shape.
    always_comb begin
        if (shape == SHP_8X8 || shape == SHP_8W4)
            stage1 = (ext * K3 + K1) >>> 1;
        else
            stage1 = (ext * K17 + K4) >>> 3;
        case (shape)
            SHP_8X8: ofs = (stage1 * K3 + K16) >>> 5;
            SHP_4W8: ofs = (stage1 * K12 + K64) >>> 7;
            default: ofs = (stage1 * K17 + K64) >>> 7;
        endcase
    end
endmodule

// File: rtl/dcadd_lane.sv
module dcadd_lane #(
    parameter int PIX_W = 8,
    parameter int ACC_W = 24
) (
    input  logic [PIX_W-1:0]        pix,
    input  logic signed [ACC_W-1:0] ofs,
    output logic [PIX_W-1:0]        res
);
    localparam logic signed [ACC_W-1:0] PIX_MAX = ACC_W'((1 << PIX_W) - 1);

    logic signed [ACC_W-1:0] sum;

    assign sum = $signed({{(ACC_W-PIX_W){1'b0}}, pix}) + ofs;

    always_comb begin
        if (sum < 0)
            res = '0;
        else if (sum > PIX_MAX)
            res = '1;
        else
            res = sum[PIX_W-1:0];
    end
endmodule

// File: rtl/dc_recon_adder.sv
module dc_recon_adder
    import dcadd_pkg::*;
#(
    parameter int DC_W  = 16,
    parameter int PIX_W = 8,
    parameter int LANES = 8,
    parameter int ACC_W = 24
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dc_load,
    input  logic [DC_W-1:0]        dc_val,
    input  logic [1:0]             blk_size,
    input  logic                   row_valid,
    input  logic [LANES*PIX_W-1:0] row_pix,
    output logic                   out_valid,
    output logic [LANES*PIX_W-1:0] out_pix
);
    localparam int HALF  = LANES / 2;
    localparam int ROW_W = LANES * PIX_W;

    typedef struct packed {
        logic signed [ACC_W-1:0] ofs;
        logic                    wide;
        logic                    vld;
        logic [ROW_W-1:0]        pix;
    } state_t;

    state_t st_d, st_q;
    logic signed [ACC_W-1:0] new_ofs;
    logic signed [ACC_W-1:0] ofs_q;
    logic [ROW_W-1:0]        lane_row;
    shape_e                  shape_in;

    assign shape_in = shape_e'(blk_size);
    assign ofs_q    = st_q.ofs;

    dcadd_scale #(.DC_W(DC_W), .ACC_W(ACC_W)) u_scale (
        .dc    ($signed(dc_val)),
        .shape (shape_in),
        .ofs   (new_ofs)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [PIX_W-1:0] res;
        dcadd_lane #(.PIX_W(PIX_W), .ACC_W(ACC_W)) u_lane (
            .pix (row_pix[k*PIX_W +: PIX_W]),
            .ofs (st_q.ofs),
            .res (res)
        );
        if (k < HALF) begin : g_low
            assign lane_row[k*PIX_W +: PIX_W] = res;
        end else begin : g_high
            assign lane_row[k*PIX_W +: PIX_W] = st_q.wide ? res : '0;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = row_valid;
        if (row_valid)
            st_d.pix = lane_row;
        if (dc_load) begin
            st_d.ofs  = new_ofs;
            st_d.wide = (shape_in == SHP_8X8) || (shape_in == SHP_8W4);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ofs  <= '0;
            st_q.wide <= 1'b1;
            st_q.vld  <= 1'b0;
            st_q.pix  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_pix   = st_q.pix;
endmodule

// File: rtl/dcadd_chk.sv
module dcadd_chk #(
    parameter int PIX_W = 8,
    parameter int LANES = 8,
    parameter int ACC_W = 24
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   dc_load,
    input logic [1:0]             blk_size,
    input logic                   row_valid,
    input logic signed [ACC_W-1:0] ofs_q,
    input logic                   out_valid,
    input logic [LANES*PIX_W-1:0] out_pix
);
    localparam int HALF_W = LANES * PIX_W / 2;

    logic wide_m;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wide_m <= 1'b1;
        else if (dc_load)
            wide_m <= !blk_size[1];
    end

    // R8
    row_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_valid |=> out_valid);

    // R8
    no_spurious_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !row_valid |=> !out_valid);

    // R9
    ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dc_load |=> $stable(ofs_q));

    // R10
    narrow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_valid && !wide_m |=> out_pix[2*HALF_W-1:HALF_W] == '0);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !row_valid |=> $stable(out_pix));

    // R7
    sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_valid && ofs_q >= 255 |=> out_pix[HALF_W-1:0] == '1);
endmodule

bind dc_recon_adder dcadd_chk #(.PIX_W(PIX_W), .LANES(LANES), .ACC_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dc_load   (dc_load),
    .blk_size  (blk_size),
    .row_valid (row_valid),
    .ofs_q     (ofs_q),
    .out_valid (out_valid),
    .out_pix   (out_pix)
);

// File: tb/dc_recon_adder_test.sv
module dc_recon_adder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dc_load = 1'b0;
    logic [15:0] dc_val = '0;
    logic [1:0]  blk_size = '0;
    logic        row_valid = 1'b0;
    logic [63:0] row_pix = '0;
    logic        out_valid;
    logic [63:0] out_pix;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int cur_ofs = 0;
    bit cur_wide = 1;

    always #10 clk = ~clk;

    dc_recon_adder uut (
        .clk(clk), .rst_n(rst_n), .dc_load(dc_load), .dc_val(dc_val),
        .blk_size(blk_size), .row_valid(row_valid), .row_pix(row_pix),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    function automatic int model_ofs(int dc, int sz);
        int a;
        if (sz < 2) a = (3 * dc + 1) >>> 1;
        else        a = (17 * dc + 4) >>> 3;
        case (sz)
            0:       return (3 * a + 16) >>> 5;
            2:       return (12 * a + 64) >>> 7;
            default: return (17 * a + 64) >>> 7;
        endcase
    endfunction

    function automatic logic [63:0] model_row(logic [63:0] pin, int ofs, bit wide);
        logic [63:0] r = '0;
        for (int k = 0; k < 8; k++) begin
            int s = int'(pin[k*8 +: 8]) + ofs;
            if (s < 0) s = 0;
            if (s > 255) s = 255;
            if (k < 4 || wide) r[k*8 +: 8] = 8'(s);
        end
        return r;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drives the load on a negedge; the new offset is active from the next row on.
    task automatic load_dc(int dc, int sz);
        @(negedge clk);
        dc_load = 1'b1; dc_val = 16'(dc); blk_size = 2'(sz);
        @(negedge clk);
        dc_load = 1'b0;
        cur_ofs = model_ofs(dc, sz);
        cur_wide = (sz < 2);
    endtask

    // Streams n rows back to back and checks each one a cycle later.
    task automatic burst(int n, string req, bit fixed, logic [63:0] fpix);
        logic [63:0] prev_exp = '0;
        for (int i = 0; i <= n; i++) begin
            @(negedge clk);
            if (i > 0) begin
                check({req, " valid"}, {63'd0, out_valid}, 64'd1);
                check(req, out_pix, prev_exp);
            end
            if (i < n) begin
                row_valid = 1'b1;
                row_pix = fixed ? fpix : {$urandom(), $urandom()};
                prev_exp = model_row(row_pix, cur_ofs, cur_wide);
            end else begin
                row_valid = 1'b0;
            end
        end
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                total++; bad++;
                $display("FAIL watchdog actual=%0d expected=<150000", cyc);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [63:0] held;
        void'($urandom(20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", {63'd0, out_valid}, 64'd0);
        check("R1 pix", out_pix, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {63'd0, out_valid}, 64'd0);
        check("R1 pix after release", out_pix, 64'd0);

        // R2 R7: zero DC passes pixels through
        load_dc(0, 0);
        burst(2, "R2 zero dc", 0, '0);
        // R2 R7: largest DC saturates to 255
        load_dc(32767, 0);
        burst(1, "R7 high sat", 1, 64'h00FF_7F80_0001_FE00);
        // R7: most negative DC clamps to 0
        load_dc(-32768, 0);
        burst(1, "R7 low sat", 1, 64'hFFFF_FFFF_FFFF_FFFF);
        // R6: dc=-11 code 0 offset -1
        load_dc(-11, 0);
        check("R6 model", 64'(cur_ofs), 64'(-1));
        burst(1, "R6 neg round 8x8", 1, 64'h6464_6464_6464_6464);
        // R6 R5: dc=-8 code 3 offset -2; R10 upper lanes masked
        load_dc(-8, 3);
        check("R6 model 4x4", 64'(cur_ofs), 64'(-2));
        burst(1, "R6 R10 neg round 4x4", 1, 64'hAAAA_AAAA_6464_6464);
        // R3 R4
        load_dc(1000, 1);
        burst(4, "R3 8w4", 0, '0);
        load_dc(-777, 2);
        burst(8, "R4 R10 4w8", 0, '0);

        // R9: load in the same cycle as a row uses the old offset
        load_dc(400, 0);
        @(negedge clk);
        row_valid = 1'b1; row_pix = 64'h1020_3040_5060_7080;
        dc_load = 1'b1; dc_val = 16'(-400); blk_size = 2'd3;
        held = model_row(row_pix, cur_ofs, cur_wide);
        @(negedge clk);
        row_valid = 1'b0; dc_load = 1'b0;
        check("R9 same cycle", out_pix, held);
        cur_ofs = model_ofs(-400, 3); cur_wide = 0;
        // R11: idle cycles keep the output
        @(negedge clk);
        check("R11 valid low", {63'd0, out_valid}, 64'd0);
        check("R11 hold", out_pix, held);
        @(negedge clk);
        check("R11 hold 2", out_pix, held);
        burst(4, "R9 R5 new ofs held", 0, '0);

        // Random blocks across all shapes
        for (int b = 0; b < 300; b++) begin
            int sz = int'($urandom_range(0, 3));
            int dc;
            if ($urandom_range(0, 1) == 1) dc = int'($urandom_range(0, 400)) - 200;
            else dc = int'($urandom_range(0, 65535)) - 32768;
            load_dc(dc, sz);
            burst((sz == 0 || sz == 2) ? 8 : 4, "R2 R3 R4 R5 random", 0, '0);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule